// File: doc/BRIEF.md
# Ready-Triggered SPI Frame Collector

This block is an SPI master that sits between an external converter and a host. The converter pulses a ready line whenever a new conversion is available. On each rising edge of that line, the block runs a fixed read sequence. The sequence fetches four consecutive device registers of three bytes each and appends the twelve received bytes to an on-chip byte buffer. The buffer holds ten such frames, 120 bytes in all.

The host is not involved while frames are being gathered. It is interrupted once, when the buffer becomes completely full. It then drains the buffer through a first-word-fall-through read port. The interrupt drops when the host empties the buffer or pulses a clear input.

Ready edges that cannot be served set a sticky overrun flag and are otherwise dropped. An edge cannot be served when it arrives during a running sequence, or when the buffer lacks room for a whole frame.

Each register read is framed by its own chip-select window. The window carries one command byte made of a configurable prefix and the register address, followed by three 0xFF filler bytes. The reply is captured during the filler bytes.

Top module: `spi_frame_collector`

## Requirements
- R1: A rising edge on `drdy_i`, after synchronisation, starts exactly one read sequence of four register reads; holding `drdy_i` high does not start another.
- R2: Each register read uses SPI mode 0 with SCLK low whenever `spi_cs_n_o` is high. It lasts one chip-select window of exactly 32 SCLK rising edges. The first byte is `CMD_PREFIX | (BASE_ADDR + i)` for register i = 0..3 in that order, sent MSB first. The next three bytes are 0xFF.
- R3: MISO is sampled on SCLK rising edges, MSB first, during the three filler bytes. The twelve bytes are appended in order: register 0 bytes 0..2 first, register 3 byte 2 last.
- R4: Between two register reads of one sequence, `spi_cs_n_o` stays high for at least one SCLK period (2·HALF_DIV clock cycles).
- R5: `full_irq_o` rises only in the cycle after the buffer reaches 120 bytes; no interrupt is produced for an individual sequence.
- R6: `full_irq_o` clears when host reads empty the buffer, or when `clear_i` pulses.
- R7: A ready edge that arrives while a sequence is running sets `overrun_o` and does not change the running sequence or start a new one.
- R8: A ready edge that arrives when fewer than 12 bytes are free, including a full buffer, causes no SPI activity and sets `overrun_o`. With exactly 12 bytes free, the sequence runs.
- R9: `rd_data_o` shows the oldest stored byte while `rd_empty_o` is low. `rd_en_i` removes that byte. `rd_en_i` has no effect on an empty buffer.
- R10: After reset: `spi_cs_n_o`=1, `spi_sclk_o`=0, `full_irq_o`=0, `overrun_o`=0, `rd_empty_o`=1.
- R11: `overrun_o` stays set until `clear_i` pulses, and `clear_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_i | input | 1 | Asynchronous data-ready line from the converter |
| clear_i | input | 1 | Clears the full interrupt and the overrun flag |
| spi_sclk_o | output | 1 | SPI serial clock, idle low |
| spi_mosi_o | output | 1 | SPI data to the device |
| spi_miso_i | input | 1 | SPI data from the device |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| rd_en_i | input | 1 | Removes the byte shown on rd_data_o |
| rd_data_o | output | 8 | Oldest byte in the buffer |
| rd_empty_o | output | 1 | Buffer holds no bytes |
| full_irq_o | output | 1 | Buffer-full interrupt |
| overrun_o | output | 1 | Sticky flag for dropped ready edges |

## Verification
The bench uses the default parameters:
- four registers of three bytes;
- ten frames;
- HALF_DIV of 2;
- address base 0x10 with prefix 0x80.

The short SCLK keeps a full buffer of ten sequences near 6,000 cycles, so several fill-and-drain rounds fit in one run. The 120-byte depth lets partial drains be tested. Draining 6 bytes leaves too little room for a frame, while draining 12 leaves exactly enough. This tests the room check at its boundary and the re-arming of the interrupt on a second fill. A bench-side device model returns bytes that depend on sequence, register and byte index, so any reordering, loss or duplication shows up in the scoreboard.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_WAIT,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/sfc_edge_sync.sv
`timescale 1ns/1ps
module sfc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R1: one pulse per edge, never two in a row
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sfc_spi_byte.sv
`timescale 1ns/1ps
module sfc_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             busy_q, busy_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic             sclk_q, sclk_d;
  logic [7:0]       tx_q, tx_d, rx_q, rx_d;
  logic             done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    div_d  = div_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        tx_d   = tx_i;
        div_d  = '0;
        bit_d  = '0;
        sclk_d = 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso_i};
      end else begin
        sclk_d = 1'b0;
        tx_d   = {tx_q[6:0], 1'b1};
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          bit_d  = '0;
        end else begin
          bit_d = bit_q + 3'd1;
        end
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      tx_q   <= 8'hFF;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  // R2: the serial clock rests low once a byte has completed
  a_r2_idle_low_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sclk_o);
endmodule

// File: rtl/sfc_byte_fifo.sv
`timescale 1ns/1ps
module sfc_byte_fifo #(
  parameter int DEPTH = 120,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [7:0]       push_data_i,
  input  logic             pop_i,
  output logic [7:0]       rd_data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             pop_ok;

  always_comb begin
    pop_ok = pop_i && (lvl_q != '0);
    wr_d   = wr_q;
    rd_d   = rd_q;
    lvl_d  = lvl_q;
    if (push_i) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
    if (pop_ok) rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
    if (push_i && !pop_ok)      lvl_d = lvl_q + LVL_W'(1);
    else if (!push_i && pop_ok) lvl_d = lvl_q - LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  assign rd_data_o = mem_q[rd_q];
  assign level_o   = lvl_q;
  assign empty_o   = (lvl_q == '0);

  // R9: the writer never pushes into a full store
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (lvl_q < LVL_W'(DEPTH)));
  // R9: a read of an empty store changes nothing
  a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/sfc_sequencer.sv
`timescale 1ns/1ps
module sfc_sequencer
  import sfc_pkg::*;
#(
  parameter int         NUM_REGS      = 4,
  parameter int         BYTES_PER_REG = 3,
  parameter int         DEPTH         = 120,
  parameter int         HALF_DIV      = 2,
  parameter logic [7:0] BASE_ADDR     = 8'h10,
  parameter logic [7:0] CMD_PREFIX    = 8'h80,
  parameter int         LVL_W         = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             clear_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             eng_done_i,
  input  logic [7:0]       eng_rx_i,
  input  logic             eng_sclk_i,
  output logic             eng_start_o,
  output logic [7:0]       eng_tx_o,
  output logic             cs_n_o,
  output logic             push_o,
  output logic [7:0]       push_data_o,
  output logic             irq_o,
  output logic             overrun_o
);
  localparam int FRAME_BYTES = NUM_REGS * BYTES_PER_REG;
  localparam int RI_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int BI_W = $clog2(BYTES_PER_REG + 1);
  localparam int WC_W = $clog2(2 * HALF_DIV + 1);
  localparam logic [RI_W-1:0]  REG_LAST  = RI_W'(NUM_REGS - 1);
  localparam logic [BI_W-1:0]  BYTE_LAST = BI_W'(BYTES_PER_REG);
  localparam logic [WC_W-1:0]  WAIT_LAST = WC_W'(2 * HALF_DIV - 1);
  localparam logic [LVL_W-1:0] START_MAX = LVL_W'(DEPTH - FRAME_BYTES);
  localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(DEPTH);

  seq_state_t      state_q, state_d;
  logic [RI_W-1:0] reg_q, reg_d;
  logic [BI_W-1:0] byte_q, byte_d;
  logic [WC_W-1:0] wait_q, wait_d;
  logic            cs_n_q, cs_n_d;
  logic            irq_q, irq_d;
  logic            ovr_q, ovr_d;
  logic            full_prev_q;
  logic            full_now;

  assign full_now = (level_i == FULL_LVL);

  always_comb begin
    state_d = state_q;
    reg_d   = reg_q;
    byte_d  = byte_q;
    wait_d  = wait_q;
    cs_n_d  = cs_n_q;
    ovr_d   = clear_i ? 1'b0 : ovr_q;
    case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          if (level_i <= START_MAX) begin
            state_d = ST_SETUP;
            reg_d   = '0;
            wait_d  = '0;
            cs_n_d  = 1'b0;
          end else begin
            ovr_d = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (wait_q == WAIT_LAST) begin
          state_d = ST_XFER;
          byte_d  = '0;
        end else begin
          wait_d = wait_q + WC_W'(1);
        end
      end
      ST_XFER: state_d = ST_WAIT;
      ST_WAIT: begin
        if (eng_done_i) begin
          if (byte_q == BYTE_LAST) begin
            state_d = ST_GAP;
            cs_n_d  = 1'b1;
            wait_d  = '0;
          end else begin
            state_d = ST_XFER;
            byte_d  = byte_q + BI_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (wait_q == WAIT_LAST) begin
          wait_d = '0;
          if (reg_q == REG_LAST) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_SETUP;
            reg_d   = reg_q + RI_W'(1);
            cs_n_d  = 1'b0;
          end
        end else begin
          wait_d = wait_q + WC_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (trig_i && (state_q != ST_IDLE)) ovr_d = 1'b1;
    if (clear_i || (level_i == '0))     irq_d = 1'b0;
    else if (full_now && !full_prev_q)  irq_d = 1'b1;
    else                                irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      reg_q       <= '0;
      byte_q      <= '0;
      wait_q      <= '0;
      cs_n_q      <= 1'b1;
      irq_q       <= 1'b0;
      ovr_q       <= 1'b0;
      full_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      reg_q       <= reg_d;
      byte_q      <= byte_d;
      wait_q      <= wait_d;
      cs_n_q      <= cs_n_d;
      irq_q       <= irq_d;
      ovr_q       <= ovr_d;
      full_prev_q <= full_now;
    end
  end

  assign eng_start_o = (state_q == ST_XFER);
  assign eng_tx_o    = (byte_q == '0) ? (CMD_PREFIX | (BASE_ADDR + 8'(reg_q))) : 8'hFF;
  assign cs_n_o      = cs_n_q;
  assign push_o      = (state_q == ST_WAIT) && eng_done_i && (byte_q != '0);
  assign push_data_o = eng_rx_i;
  assign irq_o       = irq_q;
  assign overrun_o   = ovr_q;

  // R5: the interrupt only rises on a full buffer
  a_r5_irq_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> full_prev_q);
  // R8: no sequence starts without room for a frame
  a_r8_start_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && trig_i && level_i > START_MAX) |=> (state_q == ST_IDLE));
  // R11: overrun holds until cleared
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clear_i) |=> ovr_q);
  // R2: the serial clock stays low while chip select is released
  a_r2_sclk_low_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !eng_sclk_i);
endmodule

// File: rtl/spi_frame_collector.sv
`timescale 1ns/1ps
module spi_frame_collector #(
  parameter int         NUM_REGS      = 4,
  parameter int         BYTES_PER_REG = 3,
  parameter int         NUM_FRAMES    = 10,
  parameter int         HALF_DIV      = 2,
  parameter logic [7:0] BASE_ADDR     = 8'h10,
  parameter logic [7:0] CMD_PREFIX    = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drdy_i,
  input  logic       clear_i,
  output logic       spi_sclk_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i,
  output logic       spi_cs_n_o,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  output logic       rd_empty_o,
  output logic       full_irq_o,
  output logic       overrun_o
);
  localparam int DEPTH = NUM_FRAMES * NUM_REGS * BYTES_PER_REG;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             trig;
  logic             eng_start, eng_done, eng_sclk;
  logic [7:0]       eng_tx, eng_rx;
  logic             push;
  logic [7:0]       push_data;
  logic [LVL_W-1:0] level;

  sfc_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(drdy_i), .rise_o(trig)
  );

  sfc_spi_byte #(.HALF_DIV(HALF_DIV)) u_spi (
    .clk(clk), .rst_n(rst_n), .start_i(eng_start), .tx_i(eng_tx),
    .miso_i(spi_miso_i), .sclk_o(eng_sclk), .mosi_o(spi_mosi_o),
    .rx_o(eng_rx), .done_o(eng_done)
  );

  sfc_sequencer #(
    .NUM_REGS(NUM_REGS), .BYTES_PER_REG(BYTES_PER_REG), .DEPTH(DEPTH),
    .HALF_DIV(HALF_DIV), .BASE_ADDR(BASE_ADDR), .CMD_PREFIX(CMD_PREFIX),
    .LVL_W(LVL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .clear_i(clear_i),
    .level_i(level), .eng_done_i(eng_done), .eng_rx_i(eng_rx),
    .eng_sclk_i(eng_sclk), .eng_start_o(eng_start), .eng_tx_o(eng_tx),
    .cs_n_o(spi_cs_n_o), .push_o(push), .push_data_o(push_data),
    .irq_o(full_irq_o), .overrun_o(overrun_o)
  );

  sfc_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(push_data),
    .pop_i(rd_en_i), .rd_data_o(rd_data_o), .level_o(level),
    .empty_o(rd_empty_o)
  );

  assign spi_sclk_o = eng_sclk;
endmodule

// File: tb/spi_frame_collector_tb.sv
`timescale 1ns/1ps
module spi_frame_collector_tb;
  localparam int         HALF = 2;
  localparam logic [7:0] BASE = 8'h10;
  localparam logic [7:0] PFX  = 8'h80;

  logic clk, rst_n, drdy, clr, miso, rd_en;
  logic sclk, mosi, cs_n, empty, irq, ovr;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done_flag = 0;
  logic [7:0] exp_q[$];
  int seq_exp = 0;

  // device model state
  int cs_falls = 0, cur_win = 0, rises = 0, last_rise_cyc = 0;
  logic [7:0] mosi_sh;

  spi_frame_collector #(.HALF_DIV(HALF), .BASE_ADDR(BASE), .CMD_PREFIX(PFX)) u_dut (
    .clk(clk), .rst_n(rst_n), .drdy_i(drdy), .clear_i(clr),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_n_o(cs_n),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_empty_o(empty),
    .full_irq_o(irq), .overrun_o(ovr)
  );

  initial clk = 0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dval(input int s, input int r, input int b);
    return 8'((s * 37 + r * 11 + b * 3 + 5) & 255);
  endfunction

  // SPI device model (mode 0)
  always @(negedge cs_n) begin
    if (rst_n) begin
      if (cs_falls % 4 != 0)
        chk((cyc - last_rise_cyc) >= 2 * HALF, "R4 cs high gap", cyc - last_rise_cyc, 2 * HALF);
      chk(sclk == 1'b0, "R2 sclk low at cs fall", sclk, 0);
      cur_win = cs_falls;
      cs_falls++;
      rises = 0;
      miso = 1'b0;
    end
  end
  always @(posedge cs_n) begin
    if (rst_n) begin
      chk(rises == 32, "R2 edges per window", rises, 32);
      last_rise_cyc = cyc;
    end
  end
  always @(posedge sclk) begin
    if (!cs_n) begin
      mosi_sh = {mosi_sh[6:0], mosi};
      rises++;
      if (rises == 8)
        chk(mosi_sh == (PFX | (BASE + 8'(cur_win % 4))), "R2 command byte",
            mosi_sh, PFX | (BASE + 8'(cur_win % 4)));
      else if (rises % 8 == 0)
        chk(mosi_sh == 8'hFF, "R2 filler byte", mosi_sh, 8'hFF);
    end
  end
  always @(negedge sclk) begin
    if (!cs_n && rises < 32) begin
      if (rises < 8) miso = 1'b0;
      else begin
        logic [7:0] v;
        v = dval(cur_win / 4, cur_win % 4, rises / 8 - 1);
        miso = v[7 - (rises % 8)];
      end
    end
  end

  // driver: fire one ready pulse and record what must come out
  task automatic fire(input bit accept, input int hold);
    if (accept) begin
      for (int r = 0; r < 4; r++)
        for (int b = 0; b < 3; b++) exp_q.push_back(dval(seq_exp, r, b));
      seq_exp++;
    end
    @(negedge clk); drdy = 1;
    repeat (hold) @(negedge clk);
    drdy = 0;
  endtask

  task automatic settle();
    repeat (700) @(negedge clk);
  endtask

  // monitor: pop bytes and compare against the scoreboard queue
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!empty, "R9 data present", empty, 0);
      if (exp_q.size() == 0) chk(0, "R3 unexpected byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R3 byte order", rd_data, e);
      end
      rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; @(negedge clk);
  endtask

  initial begin
    int base;
    drdy = 0; clr = 0; miso = 0; rd_en = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1, "R10 cs_n", cs_n, 1);
    chk(sclk == 0, "R10 sclk", sclk, 0);
    chk(irq == 0 && ovr == 0, "R10 flags", {irq, ovr}, 0);
    chk(empty == 1, "R10 empty", empty, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: held-high ready line gives one sequence
    fire(1, 1500); settle();
    chk(cs_falls == 4, "R1 one sequence for held level", cs_falls, 4);
    chk(irq == 0, "R5 no irq per sequence", irq, 0);
    chk(ovr == 0, "R1 no overrun", ovr, 0);

    for (int k = 0; k < 8; k++) begin fire(1, 3); settle(); end
    chk(irq == 0, "R5 no irq at 9 frames", irq, 0);
    fire(1, 3); settle();
    chk(irq == 1, "R5 irq at full", irq, 1);

    // R8: full buffer skips
    base = cs_falls;
    fire(0, 3); settle();
    chk(cs_falls == base, "R8 no spi when full", cs_falls, base);
    chk(ovr == 1, "R8 overrun on full", ovr, 1);
    pulse_clear();
    chk(irq == 0, "R6 clear drops irq", irq, 0);
    chk(ovr == 0, "R11 clear drops overrun", ovr, 0);

    // R8 boundary: 6 free skips, 12 free runs
    drain(6);
    fire(0, 3); settle();
    chk(cs_falls == base, "R8 skip with 6 free", cs_falls, base);
    chk(ovr == 1, "R8 overrun short room", ovr, 1);
    repeat (20) @(negedge clk);
    chk(ovr == 1, "R11 overrun sticky", ovr, 1);
    pulse_clear();
    drain(6);
    fire(1, 3); settle();
    chk(cs_falls == base + 4, "R8 run with 12 free", cs_falls, base + 4);
    chk(irq == 1, "R5 irq on refill", irq, 1);
    drain(120);
    @(negedge clk);
    chk(irq == 0, "R6 empty drops irq", irq, 0);
    chk(empty == 1, "R9 empty after drain", empty, 1);

    // R9: read on empty ignored
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    chk(empty == 1, "R9 empty read no effect", empty, 1);
    fire(1, 3); settle();
    drain(12);
    @(negedge clk);
    chk(empty == 1, "R9 exactly one frame", empty, 1);

    // R7: edge during busy
    base = cs_falls;
    fire(1, 3);
    repeat (100) @(negedge clk);
    fire(0, 3);
    settle();
    chk(ovr == 1, "R7 overrun while busy", ovr, 1);
    chk(cs_falls == base + 4, "R7 single sequence", cs_falls, base + 4);
    drain(12);
    @(negedge clk);
    chk(empty == 1 && exp_q.size() == 0, "R7 no extra bytes", empty, 1);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule